// File: doc/BRIEF.md
# Platform Interrupt Controller Register Core

This block collects level-sensitive interrupt requests from a parameterised set of sources and routes them to a set of interrupt targets called contexts. Each context is one privilege mode of one hart. Every source carries a 3-bit priority. Every context has its own enable bitmap and a 3-bit threshold. The block drives one external-interrupt line per context. Only the controller drives these lines. Software clears an interrupt by claiming it and then completing it, never by writing the output.

A 32-bit register bus with single-cycle requests reaches all the state. Read data appears in the cycle after the request. Source 0 is reserved and is never pending, enabled or claimed. A claim read has a side effect: it hands the winning source to software and clears its pending bit. The source stays locked out until software writes its ID back as a completion.

Top module: `plic_core`

## Requirements
- R1: The word at byte address 4·k (k < NUM_SRC) is the priority of source k+1. No priority register exists for source 0.
- R2: A priority write stores only bits [2:0] of the write data. Reads return the stored value zero-extended.
- R3: The word at 0x1000 + 4·w holds the pending bits. Bit n of that word is source 32·w+n. Bit 0 of word 0 always reads 0.
- R4: Writes anywhere in the pending region change neither the pending bits nor the ext_irq outputs.
- R5: The enable word w of context c sits at 0x2000 + 0x80·c + 4·w, with the same bit layout as R3. Bit 0 of word 0 always reads 0, and so does every bit above source NUM_SRC.
- R6: A read of an unmapped address returns 0, and a write to one has no effect. Unmapped addresses include those that are not 4-byte aligned and those at or above 0x8000.
- R7: HART_MODES holds one 4-bit mode mask per hart. The context count is the total number of set bits across those masks (3 by default). Context registers for higher context numbers are unmapped.
- R8: ext_irq[c] is 1 exactly when some enabled, pending source of context c has a priority strictly greater than the threshold at 0x4000 + 0x100·c. A source with priority 0 never counts.
- R9: A read of 0x4004 + 0x100·c returns the ID of context c's enabled pending source with the highest priority, taking the lowest ID on a tie. The read also clears that source's pending bit. If no source with nonzero priority qualifies, the read returns 0.
- R10: A claimed source cannot become pending again until its ID is written to a claim register. From the cycle after that write, a source whose level is still high is pending again.
- R11: Read data is valid in the cycle after the request. ext_irq reflects a change to pending, enable, priority or threshold state one clock after that state changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_src | input | NUM_SRC (bits NUM_SRC:1) | Level interrupt requests, bit s is source s |
| bus_en | input | 1 | Bus request strobe, one cycle per access |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| ext_irq | output | NUM_CTX | One external-interrupt line per context |

## Verification
The bench uses source 33 to test pending-word indexing. A design that computed the pending word index from the wrong base would read word 1 as zero or as priority data. Two sources of equal priority exercise the tie rule. A design that broke ties upward, or that let a claimed source re-latch before completion, would return the wrong IDs in the claim sequence. The threshold is tested at equality and with a priority-0 source, which catch a non-strict comparison and a design that treats priority 0 as valid. The bench also writes into the pending region while an interrupt is pending, which catches a design that lets software drop the interrupt. It samples ext_irq both one cycle after a threshold change and in the cycle before that, which catches any extra or missing pipeline stage.

// File: rtl/plic_pkg.sv
`timescale 1ns/1ps
// plic_pkg: shared constants, region type and context-count helper for the
// interrupt controller. Assumes a fixed 16-bit byte-address map.
package plic_pkg;

    localparam int PRIO_W  = 3;
    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 32;

    // decoded register region of the current bus access
    typedef enum logic [2:0] {
        RG_NONE,
        RG_PRIO,
        RG_PEND,
        RG_EN,
        RG_THR,
        RG_CLAIM
    } region_e;

    // number of contexts: one per set bit in each hart's 4-bit mode mask
    function automatic int count_contexts(input int harts, input logic [31:0] masks);
        int n;
        n = 0;
        for (int h = 0; h < 8; h++) begin
            if (h < harts) begin
                for (int b = 0; b < 4; b++) begin
                    n += int'(masks[h*4 + b]);
                end
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/plic_gateway.sv
`timescale 1ns/1ps
// plic_gateway: one pending bit and one in-service bit per source.
// A high level sets pending when the source is neither pending nor in
// service; a claim moves it to in service; a completion frees it.
// Assumes at most one claim or completion per cycle (single bus port).
module plic_gateway #(
    parameter int NUM_SRC = 40,
    parameter int ID_W    = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC:1]   src_lvl,
    input  logic               claim_stb,
    input  logic [ID_W-1:0]    claim_id,
    input  logic               cmpl_stb,
    input  logic [ID_W-1:0]    cmpl_id,
    output logic [NUM_SRC:0]   pend
);

    assign pend[0] = 1'b0;

    for (genvar s = 1; s <= NUM_SRC; s++) begin : g_src
        logic pend_q;
        logic busy_q;
        logic claim_hit;
        logic cmpl_hit;

        assign claim_hit = claim_stb && (claim_id == ID_W'(s));
        assign cmpl_hit  = cmpl_stb  && (cmpl_id  == ID_W'(s));

        // track pending and in-service state of this source
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q <= 1'b0;
                busy_q <= 1'b0;
            end else begin
                if (claim_hit) begin
                    pend_q <= 1'b0;
                    busy_q <= 1'b1;
                end else begin
                    if (src_lvl[s] && !pend_q && !busy_q) begin
                        pend_q <= 1'b1;
                    end
                    if (cmpl_hit) begin
                        busy_q <= 1'b0;
                    end
                end
            end
        end

        assign pend[s] = pend_q;

        // R9: a claim leaves the source in service and not pending
        assert_claim_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
            claim_hit |=> (!pend_q && busy_q));

        // R10: an in-service source never shows pending
        assert_no_rearm_R10: assert property (@(posedge clk) disable iff (!rst_n)
            busy_q |-> !pend_q);

        // R4: pending only falls through a claim, never through a bus write
        assert_pend_only_claim_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pend_q) |-> $past(claim_hit));
    end

endmodule

// File: rtl/plic_arbiter.sv
`timescale 1ns/1ps
// plic_arbiter: per-context search for the best enabled pending source and
// registered external-interrupt line. Assumes pend[0] and en[0] are 0.
module plic_arbiter
    import plic_pkg::*;
#(
    parameter int NUM_SRC = 40,
    parameter int ID_W    = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_SRC:0]                pend,
    input  logic [NUM_SRC:0]                en,
    input  logic [NUM_SRC:0][PRIO_W-1:0]    prio,
    input  logic [PRIO_W-1:0]               thr,
    output logic [ID_W-1:0]                 best_id,
    output logic                            eip
);

    logic [PRIO_W-1:0] best_prio;

    // linear scan: strictly greater keeps the lowest ID on ties, 0 never wins
    always_comb begin
        best_id   = '0;
        best_prio = '0;
        for (int s = 0; s <= NUM_SRC; s++) begin
            if (pend[s] && en[s] && (prio[s] > best_prio)) begin
                best_prio = prio[s];
                best_id   = ID_W'(s);
            end
        end
    end

    // register the threshold comparison onto the output line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eip <= 1'b0;
        end else begin
            eip <= (best_prio > thr);
        end
    end

    // R8: the line is only raised when a candidate existed a cycle earlier
    assert_eip_cand_R8: assert property (@(posedge clk) disable iff (!rst_n)
        eip |-> $past(|(pend & en)));

endmodule

// File: rtl/plic_regbus.sv
`timescale 1ns/1ps
// plic_regbus: address decode, priority/enable/threshold storage, read mux
// and claim/complete strobes. Assumes one access per cycle, aligned words,
// NUM_CTX <= 64 and NUM_SRC < 1024.
module plic_regbus
    import plic_pkg::*;
#(
    parameter int NUM_SRC = 40,
    parameter int NUM_CTX = 3,
    parameter int ID_W    = 6,
    localparam int NWORDS = (NUM_SRC + 32) / 32,
    localparam int PADW   = NWORDS * 32
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                bus_en,
    input  logic                                bus_we,
    input  logic [ADDR_W-1:0]                   bus_addr,
    input  logic [DATA_W-1:0]                   bus_wdata,
    output logic [DATA_W-1:0]                   bus_rdata,
    input  logic [NUM_SRC:0]                    pend,
    input  logic [NUM_CTX-1:0][ID_W-1:0]        best_id,
    output logic [NUM_SRC:0][PRIO_W-1:0]        prio,
    output logic [NUM_CTX-1:0][NUM_SRC:0]       en,
    output logic [NUM_CTX-1:0][PRIO_W-1:0]      thr,
    output logic                                claim_stb,
    output logic [ID_W-1:0]                     claim_id,
    output logic                                cmpl_stb,
    output logic [ID_W-1:0]                     cmpl_id
);

    // writable enable bits: sources 1..NUM_SRC only
    function automatic logic [PADW-1:0] mk_src_mask();
        logic [PADW-1:0] m;
        m = '0;
        for (int i = 1; i <= NUM_SRC; i++) begin
            m[i] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [PADW-1:0] SRC_MASK = mk_src_mask();

    logic [NUM_SRC:1][PRIO_W-1:0]   prio_q;
    logic [NUM_CTX-1:0][PADW-1:0]   en_q;
    logic [NUM_CTX-1:0][PRIO_W-1:0] thr_q;
    logic [PADW-1:0]                pend_pad;

    region_e      region;
    logic [9:0]   k_sel;
    logic [4:0]   ew_sel;
    logic [5:0]   ctx_en;
    logic [5:0]   ctx_x;
    logic [5:0]   off_x;
    logic         wr;
    logic         rd;
    logic [DATA_W-1:0] rd_val;

    assign wr = bus_en && bus_we;
    assign rd = bus_en && !bus_we;

    assign k_sel  = bus_addr[11:2];
    assign ew_sel = bus_addr[6:2];
    assign ctx_en = bus_addr[12:7];
    assign ctx_x  = bus_addr[13:8];
    assign off_x  = bus_addr[7:2];

    // classify the access into a register region, or none
    always_comb begin
        region = RG_NONE;
        if (!bus_addr[15] && (bus_addr[1:0] == 2'b00)) begin
            unique case (bus_addr[14:12])
                3'b000: if (k_sel < 10'(NUM_SRC)) region = RG_PRIO;
                3'b001: if (k_sel < 10'(NWORDS))  region = RG_PEND;
                3'b010,
                3'b011: if ((ctx_en < 6'(NUM_CTX)) && (ew_sel < 5'(NWORDS))) region = RG_EN;
                default: begin
                    if (ctx_x < 6'(NUM_CTX)) begin
                        if (off_x == 6'd0)      region = RG_THR;
                        else if (off_x == 6'd1) region = RG_CLAIM;
                    end
                end
            endcase
        end
    end

    // priority storage, low three bits of the written word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q <= '0;
        end else if (wr && (region == RG_PRIO)) begin
            for (int s = 1; s <= NUM_SRC; s++) begin
                if (k_sel == 10'(s - 1)) prio_q[s] <= bus_wdata[PRIO_W-1:0];
            end
        end
    end

    // enable bitmaps, reserved and absent source bits forced to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr && (region == RG_EN)) begin
            for (int c = 0; c < NUM_CTX; c++) begin
                for (int w = 0; w < NWORDS; w++) begin
                    if ((ctx_en == 6'(c)) && (ew_sel == 5'(w))) begin
                        en_q[c][w*32 +: 32] <= bus_wdata & SRC_MASK[w*32 +: 32];
                    end
                end
            end
        end
    end

    // per-context threshold storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q <= '0;
        end else if (wr && (region == RG_THR)) begin
            for (int c = 0; c < NUM_CTX; c++) begin
                if (ctx_x == 6'(c)) thr_q[c] <= bus_wdata[PRIO_W-1:0];
            end
        end
    end

    // pick the winning ID of the addressed context for a claim read
    always_comb begin
        claim_id = '0;
        for (int c = 0; c < NUM_CTX; c++) begin
            if (ctx_x == 6'(c)) claim_id = best_id[c];
        end
    end

    assign claim_stb = rd && (region == RG_CLAIM);
    assign cmpl_stb  = wr && (region == RG_CLAIM);
    assign cmpl_id   = bus_wdata[ID_W-1:0];

    assign pend_pad = PADW'(pend);

    // read data multiplexer, zero for unmapped addresses
    always_comb begin
        rd_val = '0;
        unique case (region)
            RG_PRIO: begin
                for (int s = 1; s <= NUM_SRC; s++) begin
                    if (k_sel == 10'(s - 1)) rd_val = DATA_W'(prio_q[s]);
                end
            end
            RG_PEND: begin
                for (int w = 0; w < NWORDS; w++) begin
                    if (k_sel == 10'(w)) rd_val = pend_pad[w*32 +: 32];
                end
            end
            RG_EN: begin
                for (int c = 0; c < NUM_CTX; c++) begin
                    for (int w = 0; w < NWORDS; w++) begin
                        if ((ctx_en == 6'(c)) && (ew_sel == 5'(w))) rd_val = en_q[c][w*32 +: 32];
                    end
                end
            end
            RG_THR: begin
                for (int c = 0; c < NUM_CTX; c++) begin
                    if (ctx_x == 6'(c)) rd_val = DATA_W'(thr_q[c]);
                end
            end
            RG_CLAIM: rd_val = DATA_W'(claim_id);
            default:  rd_val = '0;
        endcase
    end

    // register read data so it is valid the cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (rd) begin
            bus_rdata <= rd_val;
        end
    end

    assign prio = {prio_q, {PRIO_W{1'b0}}};
    assign thr  = thr_q;

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_en_out
        assign en[c] = en_q[c][NUM_SRC:0];
    end

    // R6: a read of an unmapped address returns zero
    assert_unmapped_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && (region == RG_NONE)) |=> (bus_rdata == '0));

    // R9: a claim read returns a valid source ID or zero
    assert_claim_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        claim_stb |=> (bus_rdata <= DATA_W'(NUM_SRC)));

endmodule

// File: rtl/plic_core.sv
`timescale 1ns/1ps
// plic_core: top of the interrupt controller. Wires the per-source gateway,
// the register bus and one arbiter per context. Assumes the mode masks in
// HART_MODES give at least one context.
module plic_core
    import plic_pkg::*;
#(
    parameter int          NUM_SRC    = 40,
    parameter int          HARTS      = 2,
    parameter logic [31:0] HART_MODES = 32'h0000_0031,
    localparam int         NUM_CTX    = count_contexts(HARTS, HART_MODES),
    localparam int         ID_W       = $clog2(NUM_SRC + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC:1]     irq_src,
    input  logic                 bus_en,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [NUM_CTX-1:0]   ext_irq
);

    logic [NUM_SRC:0]                pend;
    logic [NUM_SRC:0][PRIO_W-1:0]    prio;
    logic [NUM_CTX-1:0][NUM_SRC:0]   en;
    logic [NUM_CTX-1:0][PRIO_W-1:0]  thr;
    logic [NUM_CTX-1:0][ID_W-1:0]    best_id;
    logic                            claim_stb;
    logic [ID_W-1:0]                 claim_id;
    logic                            cmpl_stb;
    logic [ID_W-1:0]                 cmpl_id;

    plic_gateway #(
        .NUM_SRC (NUM_SRC),
        .ID_W    (ID_W)
    ) i_gateway (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_lvl   (irq_src),
        .claim_stb (claim_stb),
        .claim_id  (claim_id),
        .cmpl_stb  (cmpl_stb),
        .cmpl_id   (cmpl_id),
        .pend      (pend)
    );

    plic_regbus #(
        .NUM_SRC (NUM_SRC),
        .NUM_CTX (NUM_CTX),
        .ID_W    (ID_W)
    ) i_regbus (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pend      (pend),
        .best_id   (best_id),
        .prio      (prio),
        .en        (en),
        .thr       (thr),
        .claim_stb (claim_stb),
        .claim_id  (claim_id),
        .cmpl_stb  (cmpl_stb),
        .cmpl_id   (cmpl_id)
    );

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        plic_arbiter #(
            .NUM_SRC (NUM_SRC),
            .ID_W    (ID_W)
        ) i_arbiter (
            .clk     (clk),
            .rst_n   (rst_n),
            .pend    (pend),
            .en      (en[c]),
            .prio    (prio),
            .thr     (thr[c]),
            .best_id (best_id[c]),
            .eip     (ext_irq[c])
        );
    end

endmodule

// File: tb/test_plic_core.sv
`timescale 1ns/1ps
// Directed bench for plic_core: one task per scenario, each checking itself.
module test_plic_core;

    logic        clk;
    logic        rst_n;
    logic [40:1] irq_src;
    logic        bus_en;
    logic        bus_we;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [2:0]  ext_irq;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    plic_core i_plic_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_src   (irq_src),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ext_irq   (ext_irq)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R8 reset ext_irq", 32'(ext_irq), 32'h0);
        bus_read(16'h1000, d);  check("R3 reset pending word0", d, 32'h0);
        bus_read(16'h4004, d);  check("R9 claim with nothing pending", d, 32'h0);
    endtask

    task automatic t_priority();
        logic [31:0] d;
        bus_write(16'h0000, 32'hFFFF_FFFA);
        bus_read(16'h0000, d);  check("R2 priority keeps low bits", d, 32'h2);
        bus_read(16'h0004, d);  check("R1 source 2 untouched", d, 32'h0);
        bus_write(16'h009C, 32'h15);
        bus_read(16'h009C, d);  check("R1 last source priority", d, 32'h5);
        bus_write(16'h00A0, 32'h7);
        bus_read(16'h00A0, d);  check("R6 beyond last source reads 0", d, 32'h0);
        bus_read(16'h009C, d);  check("R6 unmapped write no effect", d, 32'h5);
        bus_read(16'h0002, d);  check("R6 misaligned read 0", d, 32'h0);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        bus_write(16'h2080, 32'hFFFF_FFFF);
        bus_read(16'h2080, d);  check("R5 ctx1 word0 source 0 bit", d, 32'hFFFF_FFFE);
        bus_write(16'h2084, 32'hFFFF_FFFF);
        bus_read(16'h2084, d);  check("R5 ctx1 word1 absent bits", d, 32'h0000_01FF);
        bus_read(16'h2000, d);  check("R5 ctx0 separate bitmap", d, 32'h0);
        bus_write(16'h2180, 32'hFFFF);
        bus_read(16'h2180, d);  check("R7 no fourth context enable", d, 32'h0);
        bus_write(16'h4200, 32'h6);
        bus_read(16'h4200, d);  check("R7 third context threshold", d, 32'h6);
        bus_read(16'h4300, d);  check("R7 fourth context unmapped", d, 32'h0);
        check("R7 context count", 32'($bits(ext_irq)), 32'd3);
        bus_write(16'h2080, 32'h0);
        bus_write(16'h2084, 32'h0);
    endtask

    task automatic t_pending();
        logic [31:0] d;
        @(negedge clk);
        irq_src[3] = 1'b1; irq_src[33] = 1'b1;
        idle(2);
        bus_read(16'h1000, d);  check("R3 pending word0", d, 32'h0000_0008);
        bus_read(16'h1004, d);  check("R3 pending word1 base", d, 32'h0000_0002);
        bus_write(16'h1000, 32'h0);
        bus_write(16'h1004, 32'hFFFF_FFFF);
        bus_read(16'h1000, d);  check("R4 word0 after write", d, 32'h0000_0008);
        bus_read(16'h1004, d);  check("R4 word1 after write", d, 32'h0000_0002);
        bus_read(16'h1008, d);  check("R6 past pending words", d, 32'h0);
    endtask

    task automatic t_threshold();
        bus_write(16'h4000, 32'h4);
        bus_write(16'h0008, 32'h4);
        bus_write(16'h2000, 32'h8);
        idle(2);
        check("R8 priority equal to threshold", 32'(ext_irq[0]), 32'h0);
        bus_write(16'h4000, 32'h3);
        check("R11 not before one clock", 32'(ext_irq[0]), 32'h0);
        @(negedge clk);
        check("R11 R8 raised one clock later", 32'(ext_irq[0]), 32'h1);
        bus_write(16'h0010, 32'h0);
        @(negedge clk);
        irq_src[5] = 1'b1;
        bus_write(16'h2080, 32'h20);
        bus_write(16'h4100, 32'h0);
        idle(3);
        check("R8 priority 0 never interrupts", 32'(ext_irq[1]), 32'h0);
        check("R8 idle context", 32'(ext_irq[2]), 32'h0);
    endtask

    task automatic t_claim();
        logic [31:0] d;
        bus_write(16'h0080, 32'h4);
        bus_write(16'h2004, 32'h2);
        bus_write(16'h1000, 32'h0);
        idle(2);
        check("R4 pending write keeps line", 32'(ext_irq[0]), 32'h1);
        bus_read(16'h1000, d);  check("R4 pending unchanged", d, 32'h0000_0028);
        bus_read(16'h4104, d);  check("R9 priority 0 not claimable", d, 32'h0);
        bus_read(16'h4004, d);  check("R9 tie goes to lowest ID", d, 32'd3);
        bus_read(16'h4004, d);  check("R9 next candidate", d, 32'd33);
        bus_read(16'h4004, d);  check("R9 empty claim", d, 32'd0);
        @(negedge clk);
        check("R8 line drops after claims", 32'(ext_irq[0]), 32'h0);
        bus_read(16'h1000, d);  check("R10 claimed source stays clear", d, 32'h0000_0020);
        bus_read(16'h1004, d);  check("R10 claimed source 33 clear", d, 32'h0);
        bus_write(16'h4004, 32'd3);
        idle(2);
        bus_read(16'h1000, d);  check("R10 relatch after complete", d, 32'h0000_0028);
        check("R8 line back after relatch", 32'(ext_irq[0]), 32'h1);
        bus_write(16'h0080, 32'h6);
        bus_write(16'h4004, 32'd33);
        idle(2);
        bus_read(16'h4004, d);  check("R9 higher priority wins", d, 32'd33);
        bus_read(16'h4004, d);  check("R9 lower priority after", d, 32'd3);
        @(negedge clk);
        irq_src[3] = 1'b0; irq_src[33] = 1'b0;
        bus_write(16'h4004, 32'd3);
        bus_write(16'h4004, 32'd33);
        idle(2);
        bus_read(16'h1000, d);  check("R10 no relatch when low", d, 32'h0000_0020);
        bus_read(16'h1004, d);  check("R10 word1 clear when low", d, 32'h0);
        check("R8 line low at end", 32'(ext_irq[0]), 32'h0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        rst_n = 1'b0; irq_src = '0; bus_en = 1'b0; bus_we = 1'b0;
        bus_addr = '0; bus_wdata = '0;
        idle(4);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_priority();
        t_enable();
        t_pending();
        t_threshold();
        t_claim();
        idle(2);
        finish_run();
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

endmodule